// File: doc/BRIEF.md
# Posted-Write Split-Read Bus Bridge

This block connects a 32-bit upstream system bus to a downstream peripheral bus that has a single slave port. Both sides share one clock. An upstream write is placed in a request queue and answered at once, so the upstream master can start its next transaction before the peripheral has seen the write. An upstream read also takes a slot in the same queue. The bridge does not hold the upstream bus while the read is in progress. It answers SPLIT and lets the master go.

The downstream sequencer takes queued requests in order. It raises a bus request, waits for the grant and then runs one transfer per entry. When a queued read finishes, its data and status are held in a register and a one-cycle resume pulse goes out. The master then repeats the read at the same address and gets the held data in the same cycle. Only one split read can be outstanding. Any other read that arrives while it is pending gets RETRY and is not queued. A downstream error on a posted write sets a sticky flag. A downstream error on a split read comes back as ERROR on the repeated read.

Sequencer states: `DN_IDLE` (queue empty, bus not requested), `DN_ARB` (bus requested, waiting for grant) and `DN_XFER` (slave selected, waiting for ready). The sequencer moves from IDLE to ARB when the queue is not empty, from ARB to XFER on grant, and from XFER back to IDLE on ready, which also pops the entry. Split tracker states: `SP_IDLE` (no read outstanding), `SP_WAIT` (read queued or in flight) and `SP_READY` (data held). The tracker moves from IDLE to WAIT when a read is accepted, from WAIT to READY when the downstream read completes, and from READY back to IDLE when the matching read is answered.

Top module: `pwsr_bridge`

## Requirements
- R1: An upstream write while the queue has a free slot gets `up_ack`=1 and `up_resp`=OKAY (2'b00) in the same cycle as its request.
- R2: While the queue holds DEPTH entries (default 4), an upstream write or a new read gets `up_ack`=0 and is not queued. No downstream transfer ever results from it.
- R3: `dn_sel` rises only in the cycle after `dn_grant` was seen high. While the grant is withheld, no downstream transfer starts.
- R4: Downstream transfers run strictly in acceptance order, so a read is issued only after every earlier write has completed. Address, write flag, data and size (`dn_size` = `up_size`) are passed through unchanged.
- R5: An upstream read with no split outstanding and a free slot gets `up_ack`=1 and `up_resp`=SPLIT (2'b11), and the read is queued.
- R6: While a split read is waiting for downstream data, any upstream read gets `up_ack`=1 and `up_resp`=RETRY (2'b10), and is not queued.
- R7: In the cycle after the downstream read completes, `up_resume` is high for exactly one cycle.
- R8: With data held, a read to the held address gets `up_ack`=1, OKAY and the held data in one cycle, which frees the tracker so that the next read is SPLIT again. A read to any other address gets RETRY.
- R9: A downstream error (`dn_err` with `dn_ready`) on a split read is returned as ERROR (2'b01) on the matching repeated read.
- R10: A downstream error on a posted write sets `wr_err_sticky`, which stays high until reset.
- R11: After reset, `dn_busreq`, `dn_sel`, `up_resume` and `wr_err_sticky` are low, and `up_ack` is low with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_req | input | 1 | Upstream transfer request |
| up_write | input | 1 | 1 = write, 0 = read |
| up_addr | input | ADDR_W | Upstream address |
| up_size | input | 2 | Transfer size code |
| up_wdata | input | DATA_W | Upstream write data |
| up_ack | output | 1 | Request answered this cycle; low holds the master off |
| up_resp | output | 2 | OKAY 00, ERROR 01, RETRY 10, SPLIT 11 |
| up_rdata | output | DATA_W | Read data for an OKAY/ERROR read answer |
| up_resume | output | 1 | One-cycle pulse: split read data available |
| dn_busreq | output | 1 | Downstream bus request |
| dn_grant | input | 1 | Downstream bus grant |
| dn_sel | output | 1 | Downstream slave select (transfer active) |
| dn_write | output | 1 | Downstream write flag |
| dn_addr | output | ADDR_W | Downstream address |
| dn_size | output | 2 | Downstream size code |
| dn_wdata | output | DATA_W | Downstream write data |
| dn_ready | input | 1 | Downstream transfer completes this cycle |
| dn_rdata | input | DATA_W | Downstream read data |
| dn_err | input | 1 | Downstream error, valid with dn_ready |
| wr_err_sticky | output | 1 | A posted write got a downstream error |

## Verification
The assertions assume three things about the downstream side: it keeps `dn_grant` high for as long as `dn_busreq` is high once the grant has been given, it raises `dn_ready` only while `dn_sel` is high, and it reports `dn_err` only together with `dn_ready`. The bench slave model follows these rules. It grants half a cycle after it sees a request, and it answers each selected transfer with a single ready cycle. The upstream master in the bench keeps a request for one cycle and then looks at `up_ack`. It never relies on a held-off request being kept, because it checks the hold-off itself. Grant can be withheld on demand, so the queue can be filled and a split read can be made to wait behind posted writes.

// File: rtl/pwsr_pkg.sv
package pwsr_pkg;

    typedef enum logic [1:0] {
        RSP_OKAY  = 2'b00,
        RSP_ERROR = 2'b01,
        RSP_RETRY = 2'b10,
        RSP_SPLIT = 2'b11
    } resp_t;

    typedef enum logic [1:0] {
        DN_IDLE = 2'b00,
        DN_ARB  = 2'b01,
        DN_XFER = 2'b10
    } dn_state_t;

    typedef enum logic [1:0] {
        SP_IDLE  = 2'b00,
        SP_WAIT  = 2'b01,
        SP_READY = 2'b10
    } sp_state_t;

endpackage

// File: rtl/pwsr_req_fifo.sv
module pwsr_req_fifo #(
    parameter int W     = 67,
    parameter int DEPTH = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             push,
    input  logic [W-1:0]                     din,
    input  logic                             pop,
    output logic [W-1:0]                     dout,
    output logic                             full,
    output logic                             empty,
    output logic [$clog2(DEPTH+1)-1:0]       count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST    = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign full    = (count == DEPTH_C);
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + PTR_W'(1);
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + PTR_W'(1);
            end
            unique case ({do_push, do_pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/pwsr_dn_seq.sv
module pwsr_dn_seq
    import pwsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic q_empty,
    input  logic grant,
    input  logic ready,
    output logic busreq,
    output logic sel,
    output logic done
);
    dn_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= DN_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            DN_IDLE: if (!q_empty) state_nx = DN_ARB;
            DN_ARB:  if (grant)    state_nx = DN_XFER;
            DN_XFER: if (ready)    state_nx = DN_IDLE;
            default:               state_nx = DN_IDLE;
        endcase
    end

    always_comb begin
        busreq = 1'b0;
        sel    = 1'b0;
        unique case (state)
            DN_ARB:  busreq = 1'b1;
            DN_XFER: begin
                busreq = 1'b1;
                sel    = 1'b1;
            end
            default: ;
        endcase
        done = sel && ready;
    end
endmodule

// File: rtl/pwsr_split_track.sv
module pwsr_split_track
    import pwsr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              rd_done,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              rd_err,
    input  logic              consume,
    output sp_state_t         state,
    output logic [ADDR_W-1:0] held_addr,
    output logic [DATA_W-1:0] held_data,
    output logic              held_err,
    output logic              resume
);
    sp_state_t state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SP_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SP_IDLE:  if (start)   state_nx = SP_WAIT;
            SP_WAIT:  if (rd_done) state_nx = SP_READY;
            SP_READY: if (consume) state_nx = SP_IDLE;
            default:               state_nx = SP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_addr <= '0;
            held_data <= '0;
            held_err  <= 1'b0;
            resume    <= 1'b0;
        end else begin
            resume <= (state == SP_WAIT) && rd_done;
            if ((state == SP_IDLE) && start) begin
                held_addr <= start_addr;
            end
            if ((state == SP_WAIT) && rd_done) begin
                held_data <= rd_data;
                held_err  <= rd_err;
            end
        end
    end
endmodule

// File: rtl/pwsr_bridge.sv
module pwsr_bridge
    import pwsr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_req,
    input  logic              up_write,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic [1:0]        up_size,
    input  logic [DATA_W-1:0] up_wdata,
    output logic              up_ack,
    output logic [1:0]        up_resp,
    output logic [DATA_W-1:0] up_rdata,
    output logic              up_resume,
    output logic              dn_busreq,
    input  logic              dn_grant,
    output logic              dn_sel,
    output logic              dn_write,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [1:0]        dn_size,
    output logic [DATA_W-1:0] dn_wdata,
    input  logic              dn_ready,
    input  logic [DATA_W-1:0] dn_rdata,
    input  logic              dn_err,
    output logic              wr_err_sticky
);
    localparam int ENT_W = 1 + 2 + ADDR_W + DATA_W;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [ENT_W-1:0]  q_din, q_head;
    logic              q_push, q_full, q_empty;
    logic [CNT_W-1:0]  fifo_count;
    logic              fifo_full;
    logic              h_write;
    logic [1:0]        h_size;
    logic [ADDR_W-1:0] h_addr;
    logic [DATA_W-1:0] h_data;
    logic              dn_done;
    logic              sp_start, sp_consume, sp_wait;
    sp_state_t         sp_state;
    logic [ADDR_W-1:0] sp_addr;
    logic [DATA_W-1:0] sp_data;
    logic              sp_err;
    resp_t             resp;

    assign q_din = {up_write, up_size, up_addr, up_wdata};
    assign {h_write, h_size, h_addr, h_data} = q_head;
    assign fifo_full = q_full;
    assign sp_wait   = (sp_state == SP_WAIT);

    pwsr_req_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (q_push),
        .din   (q_din),
        .pop   (dn_done),
        .dout  (q_head),
        .full  (q_full),
        .empty (q_empty),
        .count (fifo_count)
    );

    pwsr_dn_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .q_empty(q_empty),
        .grant  (dn_grant),
        .ready  (dn_ready),
        .busreq (dn_busreq),
        .sel    (dn_sel),
        .done   (dn_done)
    );

    pwsr_split_track #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (sp_start),
        .start_addr(up_addr),
        .rd_done   (dn_done && !h_write),
        .rd_data   (dn_rdata),
        .rd_err    (dn_err),
        .consume   (sp_consume),
        .state     (sp_state),
        .held_addr (sp_addr),
        .held_data (sp_data),
        .held_err  (sp_err),
        .resume    (up_resume)
    );

    // downstream drive: head entry, qualified by the select
    assign dn_write = dn_sel && h_write;
    assign dn_addr  = dn_sel ? h_addr : '0;
    assign dn_size  = dn_sel ? h_size : 2'b00;
    assign dn_wdata = (dn_sel && h_write) ? h_data : '0;

    // upstream answer, decided in the request cycle
    always_comb begin
        q_push     = 1'b0;
        sp_start   = 1'b0;
        sp_consume = 1'b0;
        up_ack     = 1'b0;
        resp       = RSP_OKAY;
        up_rdata   = '0;
        if (up_req) begin
            if (up_write) begin
                if (!q_full) begin
                    up_ack = 1'b1;
                    q_push = 1'b1;
                end
            end else begin
                unique case (sp_state)
                    SP_IDLE: begin
                        if (!q_full) begin
                            up_ack   = 1'b1;
                            resp     = RSP_SPLIT;
                            q_push   = 1'b1;
                            sp_start = 1'b1;
                        end
                    end
                    SP_WAIT: begin
                        up_ack = 1'b1;
                        resp   = RSP_RETRY;
                    end
                    SP_READY: begin
                        up_ack = 1'b1;
                        if (up_addr == sp_addr) begin
                            resp       = sp_err ? RSP_ERROR : RSP_OKAY;
                            up_rdata   = sp_data;
                            sp_consume = 1'b1;
                        end else begin
                            resp = RSP_RETRY;
                        end
                    end
                    default: ;
                endcase
            end
        end
        up_resp = resp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_err_sticky <= 1'b0;
        end else if (dn_done && h_write && dn_err) begin
            wr_err_sticky <= 1'b1;
        end
    end
endmodule

// File: rtl/pwsr_chk.sv
module pwsr_chk #(
    parameter int DEPTH = 4,
    parameter int ADDR_W = 32
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        up_req,
    input logic                        up_write,
    input logic                        up_ack,
    input logic [1:0]                  up_resp,
    input logic                        up_resume,
    input logic                        dn_sel,
    input logic                        dn_grant,
    input logic                        dn_ready,
    input logic [ADDR_W-1:0]           dn_addr,
    input logic                        wr_err_sticky,
    input logic                        fifo_full,
    input logic [$clog2(DEPTH+1)-1:0]  fifo_count,
    input logic                        sp_wait
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    p_write_ok_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (up_req && up_write && !fifo_full) |-> (up_ack && up_resp == 2'b00));

    p_full_holdoff_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (up_req && up_write && fifo_full) |-> !up_ack);

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= DEPTH_C);

    p_sel_after_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dn_sel) |-> $past(dn_grant));

    p_addr_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_sel && !dn_ready) |=> (dn_sel && $stable(dn_addr)));

    p_retry_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (up_req && !up_write && sp_wait) |-> (up_ack && up_resp == 2'b10));

    p_resume_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        up_resume |=> !up_resume);

    p_sticky_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(wr_err_sticky));
endmodule

bind pwsr_bridge pwsr_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .up_req       (up_req),
    .up_write     (up_write),
    .up_ack       (up_ack),
    .up_resp      (up_resp),
    .up_resume    (up_resume),
    .dn_sel       (dn_sel),
    .dn_grant     (dn_grant),
    .dn_ready     (dn_ready),
    .dn_addr      (dn_addr),
    .wr_err_sticky(wr_err_sticky),
    .fifo_full    (fifo_full),
    .fifo_count   (fifo_count),
    .sp_wait      (sp_wait)
);

// File: tb/pwsr_bridge_bench.sv
module pwsr_bridge_bench;
    localparam int CLK_P = 10;
    localparam logic [31:0] ERR_ADDR = 32'h0000_0EE0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        up_req = 1'b0, up_write = 1'b0;
    logic [31:0] up_addr = '0, up_wdata = '0;
    logic [1:0]  up_size = 2'b10;
    logic        up_ack, up_resume;
    logic [1:0]  up_resp;
    logic [31:0] up_rdata;
    logic        dn_busreq, dn_sel, dn_write;
    logic        dn_grant = 1'b0, dn_ready = 1'b0, dn_err = 1'b0;
    logic [31:0] dn_addr, dn_wdata;
    logic [31:0] dn_rdata = '0;
    logic [1:0]  dn_size;
    logic        wr_err_sticky;

    int total = 0, bad = 0;
    logic hold_grant = 1'b0;
    logic finished = 1'b0;

    logic [31:0] log_addr [0:63];
    logic [31:0] log_data [0:63];
    logic        log_wr   [0:63];
    logic [1:0]  log_size [0:63];
    int          log_n = 0;

    always #(CLK_P/2) clk = ~clk;

    pwsr_bridge u_pwsr_bridge (
        .clk(clk), .rst_n(rst_n),
        .up_req(up_req), .up_write(up_write), .up_addr(up_addr),
        .up_size(up_size), .up_wdata(up_wdata),
        .up_ack(up_ack), .up_resp(up_resp), .up_rdata(up_rdata),
        .up_resume(up_resume),
        .dn_busreq(dn_busreq), .dn_grant(dn_grant), .dn_sel(dn_sel),
        .dn_write(dn_write), .dn_addr(dn_addr), .dn_size(dn_size),
        .dn_wdata(dn_wdata), .dn_ready(dn_ready), .dn_rdata(dn_rdata),
        .dn_err(dn_err), .wr_err_sticky(wr_err_sticky)
    );

    function automatic logic [31:0] model_rd(input logic [31:0] a);
        return a ^ 32'h5A5A_0000;
    endfunction

    // downstream slave model: one ready cycle per selected transfer
    always @(negedge clk) begin
        dn_grant <= dn_busreq && !hold_grant;
        if (dn_sel && !dn_ready) begin
            if (log_n < 64) begin
                log_addr[log_n] = dn_addr;
                log_data[log_n] = dn_wdata;
                log_wr[log_n]   = dn_write;
                log_size[log_n] = dn_size;
            end
            log_n    = log_n + 1;
            dn_ready <= 1'b1;
            dn_rdata <= model_rd(dn_addr);
            dn_err   <= (dn_addr == ERR_ADDR);
        end else begin
            dn_ready <= 1'b0;
            dn_err   <= 1'b0;
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one upstream request cycle; starts and ends at a negedge
    task automatic up_do(input logic wr, input logic [31:0] a, input logic [31:0] d,
                         output logic ack, output logic [1:0] rsp, output logic [31:0] rd);
        up_req = 1'b1; up_write = wr; up_addr = a; up_wdata = d; up_size = 2'b10;
        #1;
        ack = up_ack; rsp = up_resp; rd = up_rdata;
        @(posedge clk);
        @(negedge clk);
        up_req = 1'b0; up_write = 1'b0;
    endtask

    task automatic drain();
        repeat (40) @(negedge clk);
        #1;
    endtask

    task automatic wait_resume(input string tag);
        int n = 0;
        while (!up_resume && n < 80) begin
            @(negedge clk);
            n++;
        end
        chk(up_resume, {tag, " resume seen"}, {31'd0, up_resume}, 32'd1);
        @(negedge clk);
        chk(!up_resume, {tag, " resume one cycle"}, {31'd0, up_resume}, 32'd0);
    endtask

    task automatic t_reset();
        chk(!dn_busreq, "R11 busreq", {31'd0, dn_busreq}, 0);
        chk(!dn_sel, "R11 sel", {31'd0, dn_sel}, 0);
        chk(!up_resume, "R11 resume", {31'd0, up_resume}, 0);
        chk(!wr_err_sticky, "R11 sticky", {31'd0, wr_err_sticky}, 0);
        chk(!up_ack, "R11 ack idle", {31'd0, up_ack}, 0);
    endtask

    task automatic t_posted();
        logic ack; logic [1:0] rsp; logic [31:0] rd;
        int base = log_n;
        for (int i = 0; i < 3; i++) begin
            up_do(1'b1, 32'h100 + 32'(i*4), 32'hD000 + 32'(i), ack, rsp, rd);
            chk(ack && rsp == 2'b00, "R1 write ack okay", {29'd0, ack, rsp}, 32'h4);
        end
        drain();
        chk(log_n == base + 3, "R4 write count", 32'(log_n - base), 3);
        for (int i = 0; i < 3; i++) begin
            chk(log_wr[base+i] && log_addr[base+i] == 32'h100 + 32'(i*4)
                && log_data[base+i] == 32'hD000 + 32'(i),
                "R4 write order/data", log_addr[base+i], 32'h100 + 32'(i*4));
        end
        chk(log_size[base] == 2'b10, "R4 size pass", {30'd0, log_size[base]}, 2);
    endtask

    task automatic t_full();
        logic ack; logic [1:0] rsp; logic [31:0] rd;
        int base = log_n;
        hold_grant = 1'b1;
        for (int i = 0; i < 4; i++) begin
            up_do(1'b1, 32'h200 + 32'(i*4), 32'hF0 + 32'(i), ack, rsp, rd);
            chk(ack, "R1 write accepted before full", {31'd0, ack}, 1);
        end
        up_do(1'b1, 32'h2FC, 32'hBAD, ack, rsp, rd);
        chk(!ack, "R2 write held off when full", {31'd0, ack}, 0);
        up_do(1'b0, 32'h2F0, 32'h0, ack, rsp, rd);
        chk(!ack, "R2 read held off when full", {31'd0, ack}, 0);
        repeat (5) @(negedge clk);
        chk(!dn_sel && dn_busreq, "R3 no select without grant",
            {30'd0, dn_sel, dn_busreq}, 32'h1);
        hold_grant = 1'b0;
        drain();
        chk(log_n == base + 4, "R2 held-off not queued", 32'(log_n - base), 4);
    endtask

    task automatic t_split();
        logic ack; logic [1:0] rsp; logic [31:0] rd;
        int base = log_n;
        hold_grant = 1'b1;
        up_do(1'b1, 32'h300, 32'hAA, ack, rsp, rd);
        up_do(1'b1, 32'h304, 32'hBB, ack, rsp, rd);
        up_do(1'b0, 32'h340, 32'h0, ack, rsp, rd);
        chk(ack && rsp == 2'b11, "R5 read split", {29'd0, ack, rsp}, 32'h7);
        up_do(1'b0, 32'h380, 32'h0, ack, rsp, rd);
        chk(ack && rsp == 2'b10, "R6 other read retry", {29'd0, ack, rsp}, 32'h6);
        up_do(1'b0, 32'h340, 32'h0, ack, rsp, rd);
        chk(ack && rsp == 2'b10, "R6 same read retry while waiting", {29'd0, ack, rsp}, 32'h6);
        hold_grant = 1'b0;
        wait_resume("R7");
        repeat (4) @(negedge clk);
        chk(log_n == base + 3, "R6 single read issued", 32'(log_n - base), 3);
        chk(log_wr[base] && log_wr[base+1] && !log_wr[base+2] && log_addr[base+2] == 32'h340,
            "R4 read after writes", log_addr[base+2], 32'h340);
        up_do(1'b0, 32'h380, 32'h0, ack, rsp, rd);
        chk(ack && rsp == 2'b10, "R8 mismatch retry", {29'd0, ack, rsp}, 32'h6);
        up_do(1'b0, 32'h340, 32'h0, ack, rsp, rd);
        chk(ack && rsp == 2'b00 && rd == model_rd(32'h340), "R8 matching read data",
            rd, model_rd(32'h340));
        up_do(1'b0, 32'h344, 32'h0, ack, rsp, rd);
        chk(ack && rsp == 2'b11, "R8 tracker freed, split again", {29'd0, ack, rsp}, 32'h7);
        wait_resume("R7 second");
        up_do(1'b0, 32'h344, 32'h0, ack, rsp, rd);
        chk(rsp == 2'b00 && rd == model_rd(32'h344), "R8 second read data",
            rd, model_rd(32'h344));
    endtask

    task automatic t_rd_err();
        logic ack; logic [1:0] rsp; logic [31:0] rd;
        up_do(1'b0, ERR_ADDR, 32'h0, ack, rsp, rd);
        chk(ack && rsp == 2'b11, "R5 error-address read split", {29'd0, ack, rsp}, 32'h7);
        wait_resume("R9");
        up_do(1'b0, ERR_ADDR, 32'h0, ack, rsp, rd);
        chk(ack && rsp == 2'b01, "R9 read error returned", {29'd0, ack, rsp}, 32'h5);
        chk(!wr_err_sticky, "R10 read error leaves sticky", {31'd0, wr_err_sticky}, 0);
    endtask

    task automatic t_wr_err();
        logic ack; logic [1:0] rsp; logic [31:0] rd;
        up_do(1'b1, ERR_ADDR, 32'h1234, ack, rsp, rd);
        chk(ack && rsp == 2'b00, "R1 error write posted okay", {29'd0, ack, rsp}, 32'h4);
        drain();
        chk(wr_err_sticky, "R10 sticky set", {31'd0, wr_err_sticky}, 1);
        up_do(1'b1, 32'h400, 32'h1, ack, rsp, rd);
        drain();
        chk(wr_err_sticky, "R10 sticky held", {31'd0, wr_err_sticky}, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_posted();
        t_full();
        t_split();
        t_rd_err();
        t_wr_err();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule